// File: doc/BRIEF.md
# Equal-Precision Reciprocal Frequency Counter

This block measures the frequency of an incoming digital signal to the same relative precision whether that signal is slow or fast. A controller supplies a coarse gate level whose exact width is unimportant. The block re-times that level to rising edges of the measured signal, so the real counting window always spans a whole number of measured periods. While the window is open, one counter runs on the measured signal and another runs on the fast reference clock. The reference counter sees the window through a two-stage synchronizer.

When the window closes, both counts, their sticky wrap flags and a timeout flag are registered at the outputs, and a one-cycle done pulse is raised in the reference domain. The controller then computes `f = f_ref * meas_count / ref_count`. If the measured signal stops while the window is open, a reference-count timeout ends the measurement early and flags it as an error. A timeout value of zero turns the timeout off.

Top module: `recip_freq_meter`

## Requirements
- R1: The window opens on the first rising edge of `sig_in` after `gate_in` goes high, and closes on the first rising edge after `gate_in` goes low. `meas_count_o` equals the number of whole `sig_in` periods spanned, taken modulo 2^MW.
- R2: `ref_count_o` equals the number of reference clock cycles during which the synchronized window was high, taken modulo 2^RW. For a window of N periods of length P, this is N*P/Tclk when the edges keep a fixed phase.
- R3: `done_o` is high for exactly one reference cycle per measurement. All result outputs change only in that cycle and hold their values otherwise.
- R4: Both counters and both wrap flags clear when a new window opens, so each result is independent of earlier ones.
- R5: `meas_ovf_o` is 1 when the measured counter wrapped at least once during the window.
- R6: `ref_ovf_o` is 1 when the reference counter wrapped at least once during the window.
- R7: With TIMEOUT_CYC nonzero, an open window whose reference count reaches TIMEOUT_CYC ends the measurement. The block pulses `done_o`, sets `timeout_o`=1 and reports `ref_count_o`=TIMEOUT_CYC. It raises no second `done_o` when that window later closes.
- R8: A measurement that closes normally reports `timeout_o`=0.
- R9: After reset, all outputs are 0.
- R10: The moment at which `gate_in` changes between two rising edges of `sig_in` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; it is also sampled by `sig_in` |
| sig_in | input | 1 | Shaped signal under measurement |
| gate_in | input | 1 | Preset gate level from the controller |
| done_o | output | 1 | One-cycle pulse when new results are valid |
| meas_count_o | output | MW | Measured-signal periods in the window |
| ref_count_o | output | RW | Reference cycles in the window |
| meas_ovf_o | output | 1 | Measured counter wrapped |
| ref_ovf_o | output | 1 | Reference counter wrapped |
| timeout_o | output | 1 | Measurement ended by timeout |

## Verification
A wrong window or counter state shows up at the next `done_o` pulse. The period count would be off by one, or the reference count would disagree with N*P/Tclk; the bench sweeps both quantities over many periods and lengths. A stuck timeout or capture state shows up within a few reference cycles, as a missing, doubled or extra done pulse, or as result outputs that change between pulses. A wrap flag that fails to clear appears on the very next small measurement.

// File: rtl/freqm_pkg.sv
package freqm_pkg;
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_CLOSE   = 2'd1,
    EV_TIMEOUT = 2'd2
  } meas_evt_e;
endpackage

// File: rtl/fm_sig_window.sv
module fm_sig_window #(
  parameter int MW = 32
) (
  input  logic          sig_clk,
  input  logic          rst,
  input  logic          gate_in,
  output logic          win_o,
  output logic [MW-1:0] cnt_o,
  output logic          ovf_o
);
  logic opening;
  assign opening = gate_in && !win_o;

  always_ff @(posedge sig_clk) begin
    if (rst) begin
      win_o <= 1'b0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      win_o <= gate_in;
      if (opening) begin
        cnt_o <= '0;
        ovf_o <= 1'b0;
      end else if (win_o) begin
        cnt_o <= cnt_o + MW'(1);
        if (&cnt_o) ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/fm_ref_ctrl.sv
module fm_ref_ctrl
  import freqm_pkg::*;
#(
  parameter int          MW          = 32,
  parameter int          RW          = 32,
  parameter int unsigned TIMEOUT_CYC = 32'd4000000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_s,
  input  logic [MW-1:0] meas_cnt,
  input  logic          meas_ovf,
  output logic          done_o,
  output logic [MW-1:0] meas_count_o,
  output logic [RW-1:0] ref_count_o,
  output logic          meas_ovf_o,
  output logic          ref_ovf_o,
  output logic          timeout_o,
  output logic          win_d_o,
  output logic [RW-1:0] run_cnt_o
);
  localparam bit          TMO_EN = (TIMEOUT_CYC != 0);
  localparam logic [RW-1:0] TMO  = RW'(TIMEOUT_CYC);

  logic      win_d, tmo_hit, rovf;
  logic [RW-1:0] rcnt;
  meas_evt_e evt;

  always_comb begin
    evt = EV_NONE;
    if (!win_s && win_d && !tmo_hit)
      evt = EV_CLOSE;
    else if (TMO_EN && win_s && win_d && !tmo_hit && rcnt == TMO)
      evt = EV_TIMEOUT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_d   <= 1'b0;
      rcnt    <= '0;
      rovf    <= 1'b0;
      tmo_hit <= 1'b0;
    end else begin
      win_d <= win_s;
      if (win_s && !win_d) begin
        rcnt    <= RW'(1);
        rovf    <= 1'b0;
        tmo_hit <= 1'b0;
      end else if (evt == EV_TIMEOUT) begin
        tmo_hit <= 1'b1;
      end else if (win_s && !tmo_hit) begin
        rcnt <= rcnt + RW'(1);
        if (&rcnt) rovf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o       <= 1'b0;
      meas_count_o <= '0;
      ref_count_o  <= '0;
      meas_ovf_o   <= 1'b0;
      ref_ovf_o    <= 1'b0;
      timeout_o    <= 1'b0;
    end else begin
      done_o <= (evt != EV_NONE);
      if (evt != EV_NONE) begin
        meas_count_o <= meas_cnt;
        ref_count_o  <= rcnt;
        meas_ovf_o   <= meas_ovf;
        ref_ovf_o    <= rovf;
        timeout_o    <= (evt == EV_TIMEOUT);
      end
    end
  end

  assign win_d_o   = win_d;
  assign run_cnt_o = rcnt;
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter #(
  parameter int          MW          = 32,
  parameter int          RW          = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 32'd4000000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sig_in,
  input  logic          gate_in,
  output logic          done_o,
  output logic [MW-1:0] meas_count_o,
  output logic [RW-1:0] ref_count_o,
  output logic          meas_ovf_o,
  output logic          ref_ovf_o,
  output logic          timeout_o
);
  logic          win_sig, win_sync, win_dly;
  logic [MW-1:0] sig_cnt;
  logic          sig_ovf;
  logic [RW-1:0] run_cnt;

  fm_sig_window #(.MW(MW)) u_win (
    .sig_clk(sig_in), .rst(rst), .gate_in(gate_in),
    .win_o(win_sig), .cnt_o(sig_cnt), .ovf_o(sig_ovf)
  );

  fm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(win_sig), .q(win_sync)
  );

  fm_ref_ctrl #(.MW(MW), .RW(RW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .win_s(win_sync),
    .meas_cnt(sig_cnt), .meas_ovf(sig_ovf),
    .done_o(done_o), .meas_count_o(meas_count_o), .ref_count_o(ref_count_o),
    .meas_ovf_o(meas_ovf_o), .ref_ovf_o(ref_ovf_o), .timeout_o(timeout_o),
    .win_d_o(win_dly), .run_cnt_o(run_cnt)
  );
endmodule

// File: rtl/recip_freq_meter_chk.sv
module recip_freq_meter_chk #(
  parameter int          MW          = 32,
  parameter int          RW          = 32,
  parameter int unsigned TIMEOUT_CYC = 32'd4000000000
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic [MW-1:0] meas_count,
  input logic [RW-1:0] ref_count,
  input logic          meas_ovf,
  input logic          ref_ovf,
  input logic          tmo,
  input logic          ws,
  input logic          wd,
  input logic [RW-1:0] rcnt
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_results_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(meas_count) && $stable(ref_count) && $stable(meas_ovf)
               && $stable(ref_ovf) && $stable(tmo)));

  assert_done_on_close_R1: assert property (@(posedge clk) disable iff (rst)
    (done && !tmo) |-> ($past(wd) && !$past(ws)));

  assert_idle_counter_R2: assert property (@(posedge clk) disable iff (rst)
    (!ws && !$past(ws)) |-> $stable(rcnt));

  generate
    if (TIMEOUT_CYC != 0) begin : g_tmo
      assert_timeout_value_R7: assert property (@(posedge clk) disable iff (rst)
        (done && tmo) |-> (ref_count == RW'(TIMEOUT_CYC)));
    end
  endgenerate
endmodule

bind recip_freq_meter recip_freq_meter_chk #(
  .MW(MW), .RW(RW), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .done(done_o), .meas_count(meas_count_o),
  .ref_count(ref_count_o), .meas_ovf(meas_ovf_o), .ref_ovf(ref_ovf_o),
  .tmo(timeout_o), .ws(win_sync), .wd(win_dly), .rcnt(run_cnt)
);

// File: tb/recip_freq_meter_tb.sv
`timescale 1ns/1ps
module recip_freq_meter_tb;
  localparam int MW = 6, RW = 12, RW2 = 6, TMO = 3000;

  logic clk = 1'b0, rst = 1'b1, sig = 1'b0, gate = 1'b0;
  bit   sig_en = 1'b1;
  int   half = 8;
  int   checks = 0, fails = 0, cyc = 0;

  logic          done, mo, ro, to;
  logic [MW-1:0] mc;
  logic [RW-1:0] rc;
  logic          done2, mo2, ro2, to2;
  logic [MW-1:0] mc2;
  logic [RW2-1:0] rc2;

  recip_freq_meter #(.MW(MW), .RW(RW), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .sig_in(sig), .gate_in(gate), .done_o(done),
    .meas_count_o(mc), .ref_count_o(rc), .meas_ovf_o(mo), .ref_ovf_o(ro),
    .timeout_o(to));

  recip_freq_meter #(.MW(MW), .RW(RW2), .TIMEOUT_CYC(0)) u_dut_ovf (
    .clk(clk), .rst(rst), .sig_in(sig), .gate_in(gate), .done_o(done2),
    .meas_count_o(mc2), .ref_count_o(rc2), .meas_ovf_o(mo2), .ref_ovf_o(ro2),
    .timeout_o(to2));

  always #4 clk = ~clk;
  initial begin
    #1;
    forever begin
      if (sig_en) sig = ~sig;
      #(half);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  bit got, g2, c_to, c_mo, c_ro, c_mo2, c_ro2;
  int c_mc, c_rc, c_mc2, c_rc2;

  task automatic wait_done(input int limit);
    got = 0; g2 = 0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (done) begin
        got = 1; g2 = done2;
        c_mc = int'(mc); c_rc = int'(rc); c_mo = mo; c_ro = ro; c_to = to;
        c_mc2 = int'(mc2); c_rc2 = int'(rc2); c_mo2 = mo2; c_ro2 = ro2;
      end
    end
  endtask

  task automatic measure(input int n, input int psig, input bit late, input bit hold_chk);
    int r;
    half = psig / 2;
    repeat (3) @(posedge sig);
    if (late) begin @(posedge sig); #1; end
    else @(negedge sig);
    gate = 1'b1;
    repeat (n) @(posedge sig);
    @(negedge sig);
    gate = 1'b0;
    wait_done(6000);
    r = n * psig / 8;
    chk("R3 done seen", got, 1);
    chk("R1 meas count", c_mc, n % 64);
    chk("R2 ref count", c_rc, r);
    chk("R5 meas wrap flag", c_mo, (n > 63) ? 1 : 0);
    chk("R8 timeout clear", c_to, 0);
    chk("R3 done aligned second unit", g2, 1);
    chk("R6 ref count narrow", c_rc2, r % 64);
    chk("R6 ref wrap flag", c_ro2, (r > 63) ? 1 : 0);
    chk("R5 meas count second unit", c_mc2, n % 64);
    if (hold_chk) begin
      @(negedge clk);
      chk("R3 single cycle done", done, 0);
      repeat (10) @(negedge clk);
      chk("R3 hold meas", int'(mc), c_mc);
      chk("R3 hold ref", int'(rc), c_rc);
    end
  endtask

  initial begin
    int plist [4];
    int nlist [6];
    plist = '{16, 24, 40, 56};
    nlist = '{1, 2, 3, 7, 20, 63};
    repeat (10) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 done", done, 0);
    chk("R9 meas", int'(mc), 0);
    chk("R9 ref", int'(rc), 0);
    chk("R9 flags", {mo, ro, to}, 0);

    // R1/R2/R6: sweep of periods and window lengths
    foreach (plist[p]) foreach (nlist[k])
      measure(nlist[k], plist[p], 1'b0, (k == 0));

    // R5: measured counter wraps at 64 periods
    measure(64, 16, 1'b0, 1'b0);
    measure(70, 16, 1'b0, 1'b0);
    // R4: flags and counts clear for the next window
    measure(5, 16, 1'b0, 1'b1);
    chk("R4 ref wrap cleared", c_ro2, 0);

    // R10: gate raised just after an edge instead of mid period
    measure(9, 24, 1'b1, 1'b0);

    // R7: measured signal stops inside the window
    half = 8;
    repeat (3) @(posedge sig);
    @(negedge sig);
    gate = 1'b1;
    repeat (5) @(posedge sig);
    sig_en = 1'b0;
    wait_done(5000);
    chk("R7 timeout done", got, 1);
    chk("R7 timeout flag", c_to, 1);
    chk("R7 timeout ref count", c_rc, TMO);
    chk("R7 meas count at stop", c_mc, 4);
    sig_en = 1'b1;
    @(negedge sig);
    gate = 1'b0;
    got = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    chk("R7 no second done", got, 0);
    chk("R7 flag held", to, 1);

    // R8: a normal window clears the timeout flag
    measure(11, 40, 1'b0, 1'b0);
    chk("R8 timeout cleared", to, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule